// File: doc/BRIEF.md
# Rotate and Mask Datapath Unit

This unit sits on a 36-bit word datapath and shapes an operand in two steps. First the operand is rotated circularly toward the most significant bit by a count. Then the rotated word is ANDed with a mask. The mask is normally right-justified, with a set number of ones in its low bits. The operand is either the incoming data word or a small literal, zero-extended to the full width.

The rotate count comes either from an immediate field of the controlling microword or from a count register. The mask width likewise comes from an immediate field or from a width register. Both registers load from the low six bits of the selected operand. A separate flag replaces the generated mask with one that covers only the upper half of the word.

The shaped word is produced combinationally from the present inputs and register contents. It is typically used to extract fields, to align constants and to test single bits or single holes.

Top module: `rotmask_unit`

## Requirements
- R1: With the rotate count taken from `rot_imm`, `result` equals the operand rotated left circularly by that count, so bit i moves to bit (i+count) mod 36; a count of 35 equals a rotate right by one.
- R2: Rotate counts from 36 to 63 act as the count minus 36.
- R3: A mask width n from `msk_imm` keeps only operand bits n-1..0 of the rotated word. n=0 gives zero, n=18 keeps bits 17:0, and any n of 36 or more keeps all 36 bits.
- R4: When `rot_sel_reg`=1, the rotate count is the count register instead of `rot_imm`, and `rot_imm` has no effect.
- R5: When `msk_sel_reg`=1, the mask width is the width register instead of `msk_imm`, and `msk_imm` has no effect.
- R6: When `upper_only`=1, the mask is ones in bits 35:18 and zeros in bits 17:0, regardless of mask width source or value.
- R7: When `lit_sel`=1, the operand is `lit_val` zero-extended to 36 bits, and `data_in` has no effect; otherwise it is `data_in`.
- R8: On a rising clock edge with `rst_n`=1, a register whose load strobe (`ld_rot` or `ld_msk`) is 1 takes operand bits 5:0; with its strobe at 0 it keeps its value.
- R9: A rising edge with `rst_n`=0 clears both registers to zero. This reset is synchronous and active low.
- R10: `result` follows changes of the operand, the fields and the selects within the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the two registers |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 36 | Data word operand |
| lit_val | input | 6 | Literal operand value |
| lit_sel | input | 1 | 1 selects the literal as operand |
| rot_imm | input | 6 | Immediate rotate count |
| rot_sel_reg | input | 1 | 1 takes the rotate count from the count register |
| msk_imm | input | 6 | Immediate mask width |
| msk_sel_reg | input | 1 | 1 takes the mask width from the width register |
| upper_only | input | 1 | 1 forces the mask to the upper half |
| ld_rot | input | 1 | Load strobe of the count register |
| ld_msk | input | 1 | Load strobe of the width register |
| result | output | 36 | Rotated and masked word |

## Verification
On every cycle, the assertions check the following:
- Upper-half mode clears the low half.
- An immediate width of zero clears the output.
- An immediate width below 36 leaves nothing above the mask.
- A zero rotate with a full mask passes the operand through unchanged.
- Register loads and holds behave as specified, and reset clears the registers.

The remaining behaviour can only be shown by the bench's sweeps, which compare against arithmetic models. This covers the rotation amount for each count, including the modulo reduction above 35, and the exact mask width for every value. It also covers register-sourced counts and widths after loads, and the fact that deselected inputs have no effect.

// File: rtl/rotmask_pkg.sv
// Package: shared widths of the rotate/mask unit.
// Assumes a single 36-bit datapath with 6-bit microword fields.
package rotmask_pkg;
    localparam int WORD_W  = 36;
    localparam int FIELD_W = 6;
endpackage

// File: rtl/rm_count_reg.sv
// Module: loadable control register with synchronous active-low clear.
// Assumes load has no effect while reset is asserted.
module rm_count_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: clear on reset, capture on load, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/rm_rotator.sv
// Module: circular left rotator with modulo reduction of the count.
// Assumes the count field may exceed WIDTH-1; it is reduced modulo WIDTH.
module rm_rotator #(
    parameter int WIDTH = 36,
    parameter int CNT_W = 6
) (
    input  logic [WIDTH-1:0] din,
    input  logic [CNT_W-1:0] cnt,
    output logic [WIDTH-1:0] dout
);
    localparam int STAGES = $clog2(WIDTH);

    logic [31:0]       cnt_wide;
    logic [STAGES-1:0] amt;
    logic [WIDTH-1:0]  stage [0:STAGES];

    // Purpose: reduce the raw count into the range 0..WIDTH-1.
    always_comb begin
        cnt_wide = {{(32-CNT_W){1'b0}}, cnt} % WIDTH;
        amt      = cnt_wide[STAGES-1:0];
    end

    assign stage[0] = din;

    // One stage per count bit: rotate by 2**k when bit k is set.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int S = (1 << k) % WIDTH;
        if (S == 0) begin : g_pass
            assign stage[k+1] = stage[k];
        end else begin : g_rot
            assign stage[k+1] = amt[k]
                ? {stage[k][WIDTH-1-S:0], stage[k][WIDTH-1:WIDTH-S]}
                : stage[k];
        end
    end

    assign dout = stage[STAGES];
endmodule

// File: rtl/rm_maskgen.sv
// Module: right-justified mask generator with an upper-half override.
// Assumes widths at or above WIDTH saturate to an all-ones mask.
module rm_maskgen #(
    parameter int WIDTH = 36,
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] width_i,
    input  logic             upper_i,
    output logic [WIDTH-1:0] mask
);
    localparam int HALF = WIDTH / 2;

    logic [31:0] width_wide;
    assign width_wide = {{(32-CNT_W){1'b0}}, width_i};

    // One comparator per bit; the override selects the upper half.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign mask[i] = upper_i ? (i >= HALF) : (width_wide > 32'(i));
    end
endmodule

// File: rtl/rotmask_unit.sv
// Module: rotate-then-mask datapath unit (top).
// Assumes the registers load from the low field bits of the selected
// operand; the output is combinational from inputs and register state.
module rotmask_unit
    import rotmask_pkg::*;
#(
    parameter int WIDTH = WORD_W,
    parameter int FW    = FIELD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_in,
    input  logic [FW-1:0]    lit_val,
    input  logic             lit_sel,
    input  logic [FW-1:0]    rot_imm,
    input  logic             rot_sel_reg,
    input  logic [FW-1:0]    msk_imm,
    input  logic             msk_sel_reg,
    input  logic             upper_only,
    input  logic             ld_rot,
    input  logic             ld_msk,
    output logic [WIDTH-1:0] result
);
    logic [WIDTH-1:0] operand;
    logic [FW-1:0]    rot_q;
    logic [FW-1:0]    msk_q;
    logic [FW-1:0]    rot_amt;
    logic [FW-1:0]    msk_width;
    logic [WIDTH-1:0] rotated;
    logic [WIDTH-1:0] mask;

    // Purpose: pick the operand, zero-extending the literal.
    always_comb begin
        operand = lit_sel ? {{(WIDTH-FW){1'b0}}, lit_val} : data_in;
    end

    rm_count_reg #(.W(FW)) u_rot_reg (
        .clk(clk), .rst_n(rst_n), .load(ld_rot),
        .d(operand[FW-1:0]), .q(rot_q)
    );

    rm_count_reg #(.W(FW)) u_msk_reg (
        .clk(clk), .rst_n(rst_n), .load(ld_msk),
        .d(operand[FW-1:0]), .q(msk_q)
    );

    // Purpose: choose immediate or register sources for count and width.
    always_comb begin
        rot_amt   = rot_sel_reg ? rot_q : rot_imm;
        msk_width = msk_sel_reg ? msk_q : msk_imm;
    end

    rm_rotator #(.WIDTH(WIDTH), .CNT_W(FW)) u_rot (
        .din(operand), .cnt(rot_amt), .dout(rotated)
    );

    rm_maskgen #(.WIDTH(WIDTH), .CNT_W(FW)) u_mask (
        .width_i(msk_width), .upper_i(upper_only), .mask(mask)
    );

    // Purpose: apply the mask to the rotated word.
    always_comb begin
        result = rotated & mask;
    end
endmodule

// File: rtl/rotmask_checker.sv
// Module: property checker bound to rotmask_unit.
// Assumes it observes the top ports plus the two register outputs.
module rotmask_checker #(
    parameter int WIDTH = 36,
    parameter int FW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] data_in,
    input logic [FW-1:0]    lit_val,
    input logic             lit_sel,
    input logic [FW-1:0]    rot_imm,
    input logic             rot_sel_reg,
    input logic [FW-1:0]    msk_imm,
    input logic             msk_sel_reg,
    input logic             upper_only,
    input logic             ld_rot,
    input logic             ld_msk,
    input logic [WIDTH-1:0] result,
    input logic [FW-1:0]    rot_q,
    input logic [FW-1:0]    msk_q
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] opnd;
    assign opnd = lit_sel ? {{(WIDTH-FW){1'b0}}, lit_val} : data_in;

    // Checks R6.
    p_upper_low_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upper_only |-> (result[HALF-1:0] == '0));

    // Checks R3.
    p_zero_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!upper_only && !msk_sel_reg && msk_imm == '0) |-> (result == '0));

    // Checks R3.
    p_no_bits_above_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!upper_only && !msk_sel_reg && 32'(msk_imm) < WIDTH)
            |-> ((result >> msk_imm) == '0));

    // Checks R1 and R7.
    p_passthrough_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!upper_only && !msk_sel_reg && 32'(msk_imm) >= WIDTH
            && !rot_sel_reg && rot_imm == '0) |-> (result == opnd));

    // Checks R8.
    p_rot_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rot |=> (rot_q == $past(opnd[FW-1:0])));

    // Checks R8.
    p_msk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_msk |=> $stable(msk_q));

    // Checks R9.
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (rot_q == '0 && msk_q == '0));
endmodule

bind rotmask_unit rotmask_checker #(.WIDTH(WIDTH), .FW(FW)) u_chk (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .lit_val(lit_val),
    .lit_sel(lit_sel), .rot_imm(rot_imm), .rot_sel_reg(rot_sel_reg),
    .msk_imm(msk_imm), .msk_sel_reg(msk_sel_reg), .upper_only(upper_only),
    .ld_rot(ld_rot), .ld_msk(ld_msk), .result(result),
    .rot_q(rot_q), .msk_q(msk_q)
);

// File: tb/sim_rotmask_unit.sv
// Bench: sweeps counts, widths and register loads against arithmetic models.
module sim_rotmask_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  data_in = '0;
    logic [5:0]    lit_val = '0;
    logic          lit_sel = 1'b0;
    logic [5:0]    rot_imm = '0;
    logic          rot_sel_reg = 1'b0;
    logic [5:0]    msk_imm = '0;
    logic          msk_sel_reg = 1'b0;
    logic          upper_only = 1'b0;
    logic          ld_rot = 1'b0;
    logic          ld_msk = 1'b0;
    logic [W-1:0]  result;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rotmask_unit u0 (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .lit_val(lit_val),
        .lit_sel(lit_sel), .rot_imm(rot_imm), .rot_sel_reg(rot_sel_reg),
        .msk_imm(msk_imm), .msk_sel_reg(msk_sel_reg), .upper_only(upper_only),
        .ld_rot(ld_rot), .ld_msk(ld_msk), .result(result)
    );

    function automatic logic [W-1:0] model_rot(logic [W-1:0] d, int c);
        int r = c % W;
        if (r == 0) return d;
        return (d << r) | (d >> (W - r));
    endfunction

    function automatic logic [W-1:0] model_mask(int n);
        if (n >= W) return '1;
        return (36'd1 << n) - 36'd1;
    endfunction

    task automatic check(input logic [W-1:0] exp, input string req);
        n_checks++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, result, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    logic [W-1:0] pats [0:3];

    initial begin
        pats[0] = 36'h000000001;
        pats[1] = 36'hFFFFFFFFE;
        pats[2] = 36'h9A5C3E17B;
        pats[3] = 36'h800000000;

        @(negedge clk);
        tick();
        tick();
        rst_n = 1'b1;
        // R9: both registers read zero after reset (rotate 0, width 0).
        rot_sel_reg = 1'b1; msk_sel_reg = 1'b1; data_in = pats[2];
        #1 check('0, "R9");
        msk_sel_reg = 1'b0; msk_imm = 6'd36;
        #1 check(pats[2], "R9");

        // R1 R2 R3 R10: sweep counts and widths from immediate fields.
        rot_sel_reg = 1'b0;
        for (int p = 0; p < 4; p++) begin
            data_in = pats[p];
            for (int c = 0; c < 64; c++) begin
                for (int m = 0; m < 64; m++) begin
                    rot_imm = 6'(c); msk_imm = 6'(m);
                    #1 check(model_rot(pats[p], c) & model_mask(m),
                             c >= 36 ? "R2" : (m == 18 ? "R3" : "R1"));
                end
            end
        end
        // R1: count 35 equals rotate right by one.
        data_in = pats[2]; rot_imm = 6'd35; msk_imm = 6'd63;
        #1 check({pats[2][0], pats[2][35:1]}, "R1");

        // R6: upper-half override for every width.
        upper_only = 1'b1; rot_imm = 6'd0;
        for (int m = 0; m < 64; m++) begin
            msk_imm = 6'(m);
            #1 check(pats[2] & 36'hFFFFC0000, "R6");
        end
        msk_sel_reg = 1'b1;
        #1 check(pats[2] & 36'hFFFFC0000, "R6");
        msk_sel_reg = 1'b0; upper_only = 1'b0;

        // R7: literal operand, data_in ignored.
        lit_sel = 1'b1; msk_imm = 6'd63;
        for (int v = 0; v < 64; v++) begin
            lit_val = 6'(v); data_in = ~36'(v);
            rot_imm = 6'd0;
            #1 check(36'(v), "R7");
            rot_imm = 6'd30;
            #1 check(model_rot(36'(v), 30), "R7");
        end

        // R8 R4: load every count through the literal, then use it.
        rot_sel_reg = 1'b1;
        for (int v = 0; v < 64; v++) begin
            lit_sel = 1'b1; lit_val = 6'(v); ld_rot = 1'b1;
            tick();
            ld_rot = 1'b0; lit_sel = 1'b0; data_in = pats[2];
            rot_imm = 6'(63 - v);
            #1 check(model_rot(pats[2], v), "R4");
        end
        // R8: hold with strobe low while operand changes.
        lit_sel = 1'b1; lit_val = 6'd5; ld_rot = 1'b1;
        tick();
        ld_rot = 1'b0; lit_val = 6'd17;
        tick();
        lit_sel = 1'b0; data_in = pats[0];
        #1 check(model_rot(pats[0], 5), "R8");
        rot_sel_reg = 1'b0; rot_imm = 6'd0;

        // R8 R5: load every width from data_in low bits, then use it.
        msk_sel_reg = 1'b1;
        for (int v = 0; v < 64; v++) begin
            data_in = {30'h3FFFFFFF, 6'(v)}; ld_msk = 1'b1;
            tick();
            ld_msk = 1'b0; data_in = '1; msk_imm = 6'(63 - v);
            #1 check(model_mask(v), "R5");
        end
        data_in = '1; ld_msk = 1'b0;
        tick();
        #1 check(model_mask(63), "R8");

        // R9: synchronous reset clears loaded registers.
        rot_sel_reg = 1'b1; rst_n = 1'b0;
        #1 check(model_mask(63), "R9");
        tick();
        rst_n = 1'b1; data_in = pats[2];
        #1 check('0, "R9");

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end
endmodule